// File: doc/BRIEF.md
# I2C Master Register and FIFO Front-End

This block sits between a 32-bit register port and a bit-level I2C byte engine. Software writes slave-address commands and data bytes into a single data port that feeds a transmit FIFO. It reads received bytes back through the same address, which drains a receive FIFO. Start, stop and not-acknowledge requests are set in a control register. The block turns them, together with the FIFO contents, into a stream of engine commands: address-with-start, write byte, read request and stop.

Engine events (a byte received, no acknowledge, arbitration lost) and the transmit FIFO draining set latched interrupt flags. Software masks them with an enable register and clears them with write-one-to-clear. Timing and filter settings are stored and presented to the engine as plain outputs. Commands reach the engine only while its run bit is set. A reset register flushes either FIFO or resets the whole block and pulses a bus-reset output.

Top module: `i2c_regfront`

## Requirements
- R1: After reset, status (0x2C) reads 0x0000_0003, and control (0x00), interrupt status (0x20) and irq are all zero.
- R2: Writing the data port (0x04) pushes the transmit FIFO. Reading it pops the receive FIFO in arrival order. Status bit 0 is transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full, bit 8 mirrors bus_busy and bit 12 is device busy.
- R3: Each FIFO holds 8 entries. A push to a full transmit FIFO is dropped and never reaches the engine. A read of an empty receive FIFO returns 0 and changes nothing.
- R4: With control bit 2 (start) set and a word with bit 8 set at the transmit head, the block issues kind 0 (start) carrying bits 7:0 of the word and then clears bit 2. Bit 0 of that word selects read mode.
- R5: After a start in write mode, data words (bit 8 clear) are issued in order as kind 1 with their byte. A command word at the head with no start request is held.
- R6: In read mode, read requests (kind 2) are issued one at a time, each after the previous byte arrives. cmd_nack carries control bit 0, which clears when used. After a read with NACK, no further reads are issued.
- R7: Control bit 1 (stop) issues kind 3 once the transmit FIFO is empty (write mode) or no read is outstanding (read mode). Device-busy then falls.
- R8: Interrupt bits are: bit 9 transmit empty while master mode (control bit 3) is on and no start is pending; bit 4 received count reached the byte-count setting (0x44), or every byte when it is 0; bit 2 no acknowledge; bit 1 arbitration lost. Writing 1s to 0x28 clears them.
- R9: irq is high exactly when a latched interrupt bit is set whose enable bit (0x24, same layout) is set.
- R10: Writing 0x34 with bit 2 set flushes the transmit FIFO, and with bit 1 set flushes the receive FIFO. Bit 0 returns every register to its reset value and pulses bus_force_rst for one cycle. 0x34 reads 0.
- R11: Commands are offered only while bus-reset register (0x50) bit 1 is set; eng_run and scl_release mirror bits 1 and 0.
- R12: Timing (0x10, 0x14, 0x18, 0x1C), filter (0x3C), byte-count (0x40, 0x44) and own-address (0x0C, 7 bits) registers read back what was written, truncated to width. Unmapped addresses read 0.
- R13: Transmit (0x48) and receive (0x4C) byte monitors count data bytes sent and received since the last start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive FIFO at the data port) |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| cmd_valid | output | 1 | Engine command offered |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_kind | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_byte | output | 8 | Address or data byte |
| cmd_nack | output | 1 | Do not acknowledge this read byte |
| evt_rx_valid | input | 1 | Engine delivered a byte |
| evt_rx_byte | input | 8 | Received byte |
| evt_nack | input | 1 | No acknowledge seen |
| evt_arb_lost | input | 1 | Arbitration lost |
| eng_busy | input | 1 | Engine busy |
| bus_busy | input | 1 | Bus busy indication |
| bus_lines | input | 2 | Line levels for monitor register 0x38 |
| eng_run | output | 1 | Engine run enable |
| scl_release | output | 1 | Release clock line hold |
| bus_force_rst | output | 1 | One-cycle full bus reset pulse |
| own_addr | output | 7 | Own address setting |
| cfg_cycle | output | CFG_W | Clock cycle count |
| cfg_low | output | CFG_W | Clock low period |
| cfg_stop_setup | output | CFG_W | Restart/stop setup time |
| cfg_data_setup | output | CFG_W | Data setup time |
| cfg_noise | output | CFG_W | Noise filter setting |

## Verification
The bench fills the transmit FIFO past its depth and confirms that the ninth word never reaches the engine. A design that wrapped its pointer would overwrite the head and send a wrong address or byte. It also pops an empty receive FIFO, where a broken design would return stale data or underflow its count. A command word queued behind data without a start request must stall, or the engine would see an address in the middle of a write. In a multi-byte read the bench checks that NACK attaches only to the next issued read and that reads stop after it, and that the byte-count interrupt fires on the exact count rather than on every byte. Clear-on-write, full reset and engine gating are each checked at the ports.

// File: rtl/i2c_regfront.sv
module i2c_regfront #(
  parameter int DEPTH = 8,
  parameter int AW    = 7,
  parameter int CFG_W = 16,
  parameter int BC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_kind,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             evt_rx_valid,
  input  logic [7:0]       evt_rx_byte,
  input  logic             evt_nack,
  input  logic             evt_arb_lost,
  input  logic             eng_busy,
  input  logic             bus_busy,
  input  logic [1:0]       bus_lines,
  output logic             eng_run,
  output logic             scl_release,
  output logic             bus_force_rst,
  output logic [6:0]       own_addr,
  output logic [CFG_W-1:0] cfg_cycle,
  output logic [CFG_W-1:0] cfg_low,
  output logic [CFG_W-1:0] cfg_stop_setup,
  output logic [CFG_W-1:0] cfg_data_setup,
  output logic [CFG_W-1:0] cfg_noise
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [9:0] INT_MASK = 10'h216;

  localparam logic [AW-1:0] A_CR   = AW'(8'h00);
  localparam logic [AW-1:0] A_DATA = AW'(8'h04);
  localparam logic [AW-1:0] A_OWN  = AW'(8'h0C);
  localparam logic [AW-1:0] A_CYC  = AW'(8'h10);
  localparam logic [AW-1:0] A_LOW  = AW'(8'h14);
  localparam logic [AW-1:0] A_SSU  = AW'(8'h18);
  localparam logic [AW-1:0] A_DSU  = AW'(8'h1C);
  localparam logic [AW-1:0] A_INT  = AW'(8'h20);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h24);
  localparam logic [AW-1:0] A_ICL  = AW'(8'h28);
  localparam logic [AW-1:0] A_STAT = AW'(8'h2C);
  localparam logic [AW-1:0] A_RST  = AW'(8'h34);
  localparam logic [AW-1:0] A_MON  = AW'(8'h38);
  localparam logic [AW-1:0] A_NF   = AW'(8'h3C);
  localparam logic [AW-1:0] A_TBC  = AW'(8'h40);
  localparam logic [AW-1:0] A_RBC  = AW'(8'h44);
  localparam logic [AW-1:0] A_TBM  = AW'(8'h48);
  localparam logic [AW-1:0] A_RBM  = AW'(8'h4C);
  localparam logic [AW-1:0] A_BRST = AW'(8'h50);

  localparam logic [1:0] K_START = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] K_READ  = 2'd2;
  localparam logic [1:0] K_STOP  = 2'd3;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [8:0]    tx_mem [DEPTH];
  logic [8:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic cr_mst, cr_sta, cr_sto, cr_nack;
  logic active, rd_mode, rd_pending, rd_last;
  logic [9:0] intr, ien;
  logic [1:0] brst;
  logic [BC_W-1:0] tbc, rbc, tbcm, rbcm;

  logic tx_empty, tx_full, rx_empty, rx_full;
  logic wr_data, rd_data, soft_rst, tx_flush, rx_flush;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [8:0] tx_head;
  logic go_start, go_write, go_stop, go_read, fire;
  logic te_set, rb_set, dev_busy;
  logic [9:0] int_set, int_clr;
  logic unused_wd;

  assign unused_wd = ^reg_wdata[31:CFG_W];

  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(DEPTH));
  assign tx_head  = tx_mem[tx_rp];

  assign wr_data  = reg_wr && reg_addr == A_DATA;
  assign rd_data  = reg_rd && reg_addr == A_DATA;
  assign soft_rst = reg_wr && reg_addr == A_RST && reg_wdata[0];
  assign tx_flush = reg_wr && reg_addr == A_RST && reg_wdata[2];
  assign rx_flush = reg_wr && reg_addr == A_RST && reg_wdata[1];

  assign go_start = cr_sta && !tx_empty && tx_head[8];
  assign go_write = !go_start && active && !rd_mode && !tx_empty && !tx_head[8];
  assign go_stop  = !go_start && cr_sto && active && !rd_pending && (rd_mode || tx_empty);
  assign go_read  = !go_start && !go_stop && active && rd_mode && !rd_pending
                    && !rd_last && !cr_sto && !rx_full;

  assign eng_run     = brst[1];
  assign scl_release = brst[0];
  assign cmd_valid   = eng_run && (go_start || go_write || go_stop || go_read);
  assign cmd_kind    = go_start ? K_START : go_write ? K_WRITE : go_read ? K_READ : K_STOP;
  assign cmd_byte    = (go_start || go_write) ? tx_head[7:0] : 8'h00;
  assign cmd_nack    = go_read && cr_nack;
  assign fire        = cmd_valid && cmd_ready;

  assign tx_push = wr_data && !tx_full;
  assign tx_pop  = fire && (cmd_kind == K_START || cmd_kind == K_WRITE);
  assign rx_push = evt_rx_valid && !rx_full;
  assign rx_pop  = rd_data && !rx_empty;

  assign te_set  = cr_mst && tx_empty && !cr_sta && !eng_busy;
  assign rb_set  = evt_rx_valid && (rbc == '0 || rbcm + BC_W'(1) == rbc);
  assign int_set = {te_set, 4'b0, rb_set, 1'b0, evt_nack, evt_arb_lost, 1'b0};
  assign int_clr = (reg_wr && reg_addr == A_ICL) ? (reg_wdata[9:0] & INT_MASK) : '0;
  assign dev_busy = active || eng_busy || cmd_valid;
  assign irq     = |(intr & ien);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[8:0];
    if (rx_push) rx_mem[rx_wp] <= {1'b0, evt_rx_byte};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst || tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst || rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_force_rst <= 1'b0;
    else        bus_force_rst <= soft_rst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      {cr_mst, cr_sta, cr_sto, cr_nack} <= '0;
      {active, rd_mode, rd_pending, rd_last} <= '0;
      intr <= '0; ien <= '0; brst <= '0;
      tbc <= '0; rbc <= '0; tbcm <= '0; rbcm <= '0;
      own_addr <= '0; cfg_cycle <= '0; cfg_low <= '0;
      cfg_stop_setup <= '0; cfg_data_setup <= '0; cfg_noise <= '0;
    end else begin
      if (fire) begin
        case (cmd_kind)
          K_START: begin
            cr_sta <= 1'b0; active <= 1'b1; rd_mode <= tx_head[0];
            rd_last <= 1'b0; rd_pending <= 1'b0; tbcm <= '0; rbcm <= '0;
          end
          K_WRITE: tbcm <= tbcm + BC_W'(1);
          K_READ: begin
            rd_pending <= 1'b1;
            if (cr_nack) begin rd_last <= 1'b1; cr_nack <= 1'b0; end
          end
          default: begin cr_sto <= 1'b0; active <= 1'b0; rd_mode <= 1'b0; end
        endcase
      end
      if (evt_rx_valid) begin rd_pending <= 1'b0; rbcm <= rbcm + BC_W'(1); end
      if (evt_nack) rd_pending <= 1'b0;
      if (evt_arb_lost) begin active <= 1'b0; rd_mode <= 1'b0; rd_pending <= 1'b0; end
      if (cr_sto && !active && !cr_sta) cr_sto <= 1'b0;
      intr <= (intr & ~int_clr) | int_set;
      if (reg_wr) begin
        case (reg_addr)
          A_CR:   {cr_mst, cr_sta, cr_sto, cr_nack} <= reg_wdata[3:0];
          A_OWN:  own_addr <= reg_wdata[6:0];
          A_CYC:  cfg_cycle <= reg_wdata[CFG_W-1:0];
          A_LOW:  cfg_low <= reg_wdata[CFG_W-1:0];
          A_SSU:  cfg_stop_setup <= reg_wdata[CFG_W-1:0];
          A_DSU:  cfg_data_setup <= reg_wdata[CFG_W-1:0];
          A_NF:   cfg_noise <= reg_wdata[CFG_W-1:0];
          A_IEN:  ien <= reg_wdata[9:0] & INT_MASK;
          A_TBC:  tbc <= reg_wdata[BC_W-1:0];
          A_RBC:  rbc <= reg_wdata[BC_W-1:0];
          A_BRST: brst <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CR:   reg_rdata = 32'({cr_mst, cr_sta, cr_sto, cr_nack});
      A_DATA: reg_rdata = rx_empty ? 32'h0 : 32'(rx_mem[rx_rp]);
      A_OWN:  reg_rdata = 32'(own_addr);
      A_CYC:  reg_rdata = 32'(cfg_cycle);
      A_LOW:  reg_rdata = 32'(cfg_low);
      A_SSU:  reg_rdata = 32'(cfg_stop_setup);
      A_DSU:  reg_rdata = 32'(cfg_data_setup);
      A_INT:  reg_rdata = 32'(intr);
      A_IEN:  reg_rdata = 32'(ien);
      A_STAT: reg_rdata = 32'({dev_busy, 3'b0, bus_busy, 4'b0,
                               rx_full, !rx_empty, !tx_full, tx_empty});
      A_MON:  reg_rdata = 32'(bus_lines);
      A_NF:   reg_rdata = 32'(cfg_noise);
      A_TBC:  reg_rdata = 32'(tbc);
      A_RBC:  reg_rdata = 32'(rbc);
      A_TBM:  reg_rdata = 32'(tbcm);
      A_RBM:  reg_rdata = 32'(rbcm);
      A_BRST: reg_rdata = 32'(brst);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_regfront_chk.sv
module i2c_regfront_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [AW-1:0]          reg_addr,
  input logic [31:0]            reg_wdata,
  input logic                   irq,
  input logic                   eng_run,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic [1:0]             cmd_kind,
  input logic                   evt_nack,
  input logic                   active,
  input logic [9:0]             intr,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt
);
  logic rst_wr;
  assign rst_wr = reg_wr && reg_addr == AW'(8'h34);

  // R11
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !eng_run |-> !cmd_valid);
  // R3
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= ($clog2(DEPTH)+1)'(DEPTH));
  // R3
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= ($clog2(DEPTH)+1)'(DEPTH));
  // R7
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'd3) |=> !active);
  // R8
  nack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_nack && !(rst_wr && reg_wdata[0])) |=> intr[2]);
  // R10
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && reg_wdata[2]) |=> tx_cnt == '0);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq) |-> $past(reg_wr));
endmodule

bind i2c_regfront i2c_regfront_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq(irq), .eng_run(eng_run), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .evt_nack(evt_nack), .active(active), .intr(intr),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_i2c_regfront.sv
`timescale 1ns/100ps
module test_i2c_regfront;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [6:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, cmd_valid, cmd_nack, eng_run, scl_release, bus_force_rst;
  logic cmd_ready = 1;
  logic [1:0] cmd_kind;
  logic [7:0] cmd_byte;
  logic evt_rx_valid = 0, evt_nack = 0, evt_arb_lost = 0, eng_busy = 0, bus_busy = 0;
  logic [7:0] evt_rx_byte = 0;
  logic [1:0] bus_lines = 2'b11;
  logic [6:0] own_addr;
  logic [15:0] cfg_cycle, cfg_low, cfg_stop_setup, cfg_data_setup, cfg_noise;

  int checks = 0, errors = 0;
  int log_n = 0;
  logic [1:0] log_k [64];
  logic [7:0] log_b [64];
  logic       log_x [64];
  logic [31:0] v;

  i2c_regfront i_i2c_regfront (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (rst_n && cmd_valid && cmd_ready && log_n < 64) begin
      log_k[log_n] <= cmd_kind; log_b[log_n] <= cmd_byte; log_x[log_n] <= cmd_nack;
      log_n <= log_n + 1;
    end

  localparam logic [6:0]  TV_A [12] = '{7'h10, 7'h14, 7'h18, 7'h1C, 7'h3C, 7'h40,
                                        7'h44, 7'h0C, 7'h08, 7'h54, 7'h24, 7'h50};
  localparam logic [31:0] TV_D [12] = '{32'h1234ABCD, 32'h62, 32'h62, 32'h0C, 32'hFFFF0007,
                                        32'h55, 32'h10203, 32'hFF, 32'hFFFFFFFF, 32'hFFFF,
                                        32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [31:0] TV_E [12] = '{32'hABCD, 32'h62, 32'h62, 32'h0C, 32'h7, 32'h55,
                                        32'h03, 32'h7F, 32'h0, 32'h0, 32'h216, 32'h3};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    evt_rx_byte = b; evt_rx_valid = 1;
    @(negedge clk); evt_rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_log(input string req, input int i, input logic [1:0] k,
                         input logic [7:0] b, input logic x);
    chk(req, {21'b0, log_k[i], log_b[i], log_x[i]}, {21'b0, k, b, x});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    rd(7'h2C, v); chk("R1 status", v, 32'h3);
    rd(7'h00, v); chk("R1 control", v, 0);
    rd(7'h20, v); chk("R1 intr", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R12 table of register write/readback vectors
    for (int i = 0; i < 12; i++) begin
      wr(TV_A[i], TV_D[i]);
      rd(TV_A[i], v);
      chk($sformatf("R12 vec %0d", i), v, TV_E[i]);
    end
    chk("R12 cfg_cycle port", {16'b0, cfg_cycle}, 32'hABCD);
    chk("R11 run/release", {30'b0, eng_run, scl_release}, 32'h3);
    rd(7'h38, v); chk("R12 monitor", v, 32'h3);

    // R10 full reset
    wr(7'h34, 32'h1);
    chk("R10 bus reset pulse", {31'b0, bus_force_rst}, 1);
    @(negedge clk);
    chk("R10 pulse ends", {31'b0, bus_force_rst}, 0);
    rd(7'h10, v); chk("R10 cycle cleared", v, 0);
    rd(7'h50, v); chk("R10 run cleared", v, 0);
    rd(7'h34, v); chk("R10 reads zero", v, 0);

    // R11/R4/R5 write transfer, engine gated first
    wr(7'h04, 32'h1A0); wr(7'h04, 32'h11); wr(7'h04, 32'h22); wr(7'h04, 32'h33);
    rd(7'h2C, v); chk("R2 status with tx data", v, 32'h2);
    wr(7'h00, 32'h0C);
    idle(5);
    chk("R11 no command while stopped", log_n, 0);
    wr(7'h50, 32'h3);
    idle(8);
    chk("R5 command count", log_n, 4);
    chk_log("R4 start addr", 0, 2'd0, 8'hA0, 0);
    chk_log("R5 write 1", 1, 2'd1, 8'h11, 0);
    chk_log("R5 write 2", 2, 2'd1, 8'h22, 0);
    chk_log("R5 write 3", 3, 2'd1, 8'h33, 0);
    rd(7'h00, v); chk("R4 start bit cleared", v, 32'h8);
    rd(7'h48, v); chk("R13 tx monitor", v, 3);
    rd(7'h20, v); chk("R8 tx empty flag", v, 32'h200);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(7'h24, 32'h200);
    chk("R9 irq enabled", {31'b0, irq}, 1);
    wr(7'h24, 32'h0);

    // R5 held command word, then repeated start in read mode with NACK (R6)
    wr(7'h04, 32'h1A1);
    idle(4);
    chk("R5 command word held", log_n, 4);
    wr(7'h00, 32'h0D);
    idle(4);
    chk("R6 single read issued", log_n, 6);
    chk_log("R4 repeated start", 4, 2'd0, 8'hA1, 0);
    chk_log("R6 read with nack", 5, 2'd2, 8'h00, 1);
    rx(8'h5A);
    idle(4);
    chk("R6 no read after nack", log_n, 6);
    rd(7'h20, v); chk("R8 rx count flag", v & 32'h10, 32'h10);
    rd(7'h4C, v); chk("R13 rx monitor", v, 1);
    rd(7'h2C, v); chk("R2 status busy rx", v, 32'h1007);
    rd(7'h04, v); chk("R2 pop byte", v, 32'h5A);
    rd(7'h04, v); chk("R3 empty pop", v, 0);
    rd(7'h2C, v); chk("R3 empty unchanged", v, 32'h1003);
    wr(7'h00, 32'h0A);
    idle(3);
    chk_log("R7 stop", 6, 2'd3, 8'h00, 0);
    rd(7'h2C, v); chk("R7 busy cleared", v, 32'h3);

    // R6/R8 multi-byte read with count setting 2
    wr(7'h28, 32'h216);
    wr(7'h04, 32'h1A1); wr(7'h44, 32'h2); wr(7'h00, 32'h0C);
    idle(4);
    base = 7;
    chk_log("R6 read 1 no nack", base + 1, 2'd2, 8'h00, 0);
    rx(8'h01); idle(3);
    rd(7'h20, v); chk("R8 count not reached", v & 32'h10, 0);
    rx(8'h02); idle(3);
    rd(7'h20, v); chk("R8 count reached", v & 32'h10, 32'h10);
    chk_log("R6 read 3 no nack", base + 3, 2'd2, 8'h00, 0);
    wr(7'h00, 32'h09);
    idle(3);
    chk("R6 one read outstanding", log_n, base + 4);
    rx(8'h03); idle(3);
    chk_log("R6 nack on next read", base + 4, 2'd2, 8'h00, 1);
    rx(8'h04); idle(3);
    chk("R6 reads end", log_n, base + 5);
    wr(7'h00, 32'h0A); idle(3);
    chk_log("R7 stop after read", base + 5, 2'd3, 8'h00, 0);
    for (int i = 1; i <= 4; i++) begin
      rd(7'h04, v); chk("R2 rx order", v, i);
    end

    // R8 no-ack and arbitration flags, clear and irq
    wr(7'h00, 32'h0);
    wr(7'h28, 32'h216);
    rd(7'h20, v); chk("R8 cleared", v, 0);
    evt_nack = 1; @(negedge clk); evt_nack = 0;
    evt_arb_lost = 1; @(negedge clk); evt_arb_lost = 0;
    rd(7'h20, v); chk("R8 nack and arb", v, 32'h6);
    wr(7'h24, 32'h2);
    chk("R9 arb enabled", {31'b0, irq}, 1);
    wr(7'h28, 32'h2);
    chk("R9 irq after clear", {31'b0, irq}, 0);
    rd(7'h20, v); chk("R8 partial clear", v, 32'h4);
    wr(7'h24, 32'h0);

    // R3 overflow: ninth push dropped
    base = log_n;
    wr(7'h04, 32'h1A0);
    for (int i = 1; i <= 8; i++) wr(7'h04, i);
    rd(7'h2C, v); chk("R3 tx full status", v, 32'h0);
    wr(7'h00, 32'h0C);
    idle(12);
    chk("R3 sent count", log_n - base, 8);
    chk_log("R3 last byte", base + 7, 2'd1, 8'h07, 0);
    wr(7'h00, 32'h0A); idle(3);

    // R10 FIFO flushes, R3 rx full
    wr(7'h00, 32'h0);
    wr(7'h50, 32'h0);
    wr(7'h04, 32'h0AA); wr(7'h04, 32'h0BB);
    wr(7'h34, 32'h4);
    rd(7'h2C, v); chk("R10 tx flush", v, 32'h3);
    for (int i = 0; i < 9; i++) rx(8'(i));
    bus_busy = 1;
    rd(7'h2C, v); chk("R3 rx full status", v, 32'h10F);
    bus_busy = 0;
    rd(7'h04, v); chk("R3 ninth byte dropped, head kept", v, 0);
    wr(7'h34, 32'h2);
    rd(7'h2C, v); chk("R10 rx flush", v, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule